// File: doc/BRIEF.md
# Threshold-Triggered Audio Reverser Controller

This controller drives the addressing of a stereo sample memory so that a loud passage in the input is replayed backwards. Left and right words are stored at neighbouring addresses of a circular memory. While the controller is in forward mode it records each stereo period into that memory. When the left input grows loud enough, the controller waits until a chosen amount of further audio has been recorded. It then stops recording and plays the stored audio backwards, down to a point slightly before the moment the trigger fired. At that point it asks an external mixer to crossfade back to live audio, resumes recording, and waits through a holdoff interval before it can be triggered again.

Each stereo period begins with a one-cycle sample strobe. The two cycles after an accepted strobe are access slots: the left slot first, then the right slot. In each slot the controller presents a write address and a read address, each with its own enable. After reset the controller first sweeps the whole memory with zero writes. The codec link, the memory timing and the crossfade arithmetic are outside this block.

Top module: `rev_ctrl`

## Requirements
- R1: In forward mode an accepted strobe triggers when the left sample's magnitude is at least THRESH. The magnitude of a negative sample is its bitwise inverse: 0xC6FF triggers, 0xC700 does not, 0x3900 triggers, 0x38FF does not. The mode then becomes armed.
- R2: On a trigger, the bottom mark becomes the updated write pointer minus BACKTRACK, wrapped to AW bits.
- R3: While armed, recording continues. In the period when the updated write pointer equals bottom + (buf_size << SIZE_SHIFT) (wrapped), the mode becomes reversing. In that same period, reads start at that pointer minus 3 (left) and minus 2 (right).
- R4: In each period that reads, the left read address is the playback pointer minus 3 and the right read address is the pointer minus 2. The pointer then moves back by 2.
- R5: In a reversing period whose playback pointer equals the bottom mark, the mode becomes crossfading and xfade_start is high for one cycle. That period still reads but does not write. Writes resume in the next period.
- R6: In crossfading, a strobe that arrives with xfade_done high enters holdoff, and that period still reads. Holdoff lasts HOLDOFF/2 periods, with no reads. The last of these periods returns the mode to forward.
- R7: In every period that does not start in reversing mode, the left slot writes at the write pointer + 1 and the right slot at + 2. The pointer then holds the right address. No writes occur in a period that starts in reversing mode.
- R8: After reset, mem_zero and wr_en stay high for 2^AW cycles while wr_addr counts from 0 upwards. Afterwards the write pointer reads 1, the read address reads RD_START wrapped to AW bits, and the mode is forward.
- R9: A sample above threshold has no effect in the armed, reversing, crossfading and holdoff modes.
- R10: A strobe is ignored during the zero sweep and during the two access slots.
- R11: mode_o encodes forward=0, armed=1, reversing=2, crossfading=3, holdoff=4. rev_sel is high only in reversing mode. slot_right is high only in the right slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_stb | input | 1 | Start of a stereo period |
| smp_left | input | DW | Left input sample, signed |
| buf_size | input | SZW | Wait length after trigger, in units of 2^SIZE_SHIFT addresses |
| xfade_done | input | 1 | Crossfade finished, sampled with smp_stb |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | AW | Memory write address |
| rd_en | output | 1 | Memory read enable |
| rd_addr | output | AW | Memory read address |
| slot_right | output | 1 | High in the right-channel access slot |
| mem_zero | output | 1 | Zero sweep in progress; write data must be zero |
| rev_sel | output | 1 | Output should come from reversed playback |
| xfade_start | output | 1 | One-cycle pulse starting the crossfade |
| mode_o | output | 3 | Current mode |

## Verification
The bench builds the controller with AW=12, SIZE_SHIFT=4, BACKTRACK=0x20 and HOLDOFF=0x10. With these values the start-up sweep takes 4096 cycles, and a full event with buf_size=4 takes only a few hundred cycles. That event runs the trigger, the arming wait and 33 backward periods down to the bottom mark, then the crossfade and the eight holdoff periods, and finally retriggers. The short memory also lets the bottom mark wrap below address zero, which exercises the modular compare in both the arming match and the end-of-playback match.

// File: rtl/rev_ctrl.sv
module rev_ctrl #(
  parameter int AW         = 18,
  parameter int DW         = 16,
  parameter int SZW        = 10,
  parameter int SIZE_SHIFT = 8,
  parameter int THRESH     = 'h3900,
  parameter int BACKTRACK  = 'h800,
  parameter int HOLDOFF    = 'hF00,
  parameter int RD_START   = 'h1FF01
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_stb,
  input  logic [DW-1:0]  smp_left,
  input  logic [SZW-1:0] buf_size,
  input  logic           xfade_done,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic           slot_right,
  output logic           mem_zero,
  output logic           rev_sel,
  output logic           xfade_start,
  output logic [2:0]     mode_o
);

  localparam int HW = 16;
  localparam logic [AW-1:0] BT   = AW'(BACKTRACK);
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [AW-1:0] RD0  = AW'(RD_START);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  typedef enum logic [2:0] {
    M_FWD  = 3'd0,
    M_ARM  = 3'd1,
    M_REV  = 3'd2,
    M_XF   = 3'd3,
    M_HOLD = 3'd4
  } mode_t;

  mode_t         mode;
  logic [AW-1:0] wr_ptr, rd_ptr, bottom, clr_cnt;
  logic [HW-1:0] hold;
  logic [1:0]    slot;
  logic          clr_busy, wr_act, rd_act, xs;

  wire [DW-1:0] mag    = smp_left[DW-1] ? ~smp_left : smp_left;
  wire          loud   = mag >= DW'(THRESH);
  wire [AW-1:0] span   = AW'({buf_size, {SIZE_SHIFT{1'b0}}});
  wire          acc    = smp_stb && slot == 2'd0 && !clr_busy;
  wire          writing = mode != M_REV;
  wire [AW-1:0] wr_nx  = writing ? wr_ptr + TWO : wr_ptr;
  wire          arm_hit = wr_nx == bottom + span;
  wire          at_bot  = rd_ptr == bottom;
  wire [HW-1:0] hold_nx = hold - HW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_busy <= 1'b1;
      clr_cnt  <= '0;
    end else if (clr_busy) begin
      clr_cnt <= clr_cnt + ONE;
      if (clr_cnt == LAST) clr_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= 2'd0;
    end else if (acc) begin
      slot <= 2'd1;
    end else if (slot == 2'd1) begin
      slot <= 2'd2;
    end else begin
      slot <= 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_FWD;
      wr_ptr <= ONE;
      rd_ptr <= RD0;
      bottom <= '0;
      hold   <= '0;
      wr_act <= 1'b0;
      rd_act <= 1'b0;
      xs     <= 1'b0;
    end else begin
      xs <= 1'b0;
      if (acc) begin
        wr_ptr <= wr_nx;
        wr_act <= writing;
        rd_act <= (mode == M_ARM && arm_hit) || mode == M_REV || mode == M_XF;
        case (mode)
          M_FWD: if (loud) begin
            bottom <= wr_nx - BT;
            mode   <= M_ARM;
          end
          M_ARM: if (arm_hit) begin
            rd_ptr <= wr_nx - TWO;
            mode   <= M_REV;
          end
          M_REV: begin
            rd_ptr <= rd_ptr - TWO;
            if (at_bot) begin
              mode <= M_XF;
              xs   <= 1'b1;
            end
          end
          M_XF: begin
            rd_ptr <= rd_ptr - TWO;
            if (xfade_done) begin
              hold <= HW'(HOLDOFF);
              mode <= M_HOLD;
            end
          end
          M_HOLD: begin
            hold <= hold_nx;
            if (hold_nx == '0) mode <= M_FWD;
          end
          default: mode <= M_FWD;
        endcase
      end
    end
  end

  assign mem_zero    = clr_busy;
  assign slot_right  = slot == 2'd2;
  assign wr_en       = clr_busy || (slot != 2'd0 && wr_act);
  assign wr_addr     = clr_busy ? clr_cnt : (slot == 2'd1 ? wr_ptr - ONE : wr_ptr);
  assign rd_en       = slot != 2'd0 && rd_act;
  assign rd_addr     = slot == 2'd1 ? rd_ptr - ONE : rd_ptr;
  assign rev_sel     = mode == M_REV;
  assign xfade_start = xs;
  assign mode_o      = mode;

  initial begin
    assert (HOLDOFF > 0 && HOLDOFF % 2 == 0) else $error("HOLDOFF must be even and nonzero");
  end

  AST_WR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_right && wr_en) |-> wr_addr == $past(wr_addr) + ONE); // R7
  AST_RD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_right && rd_en) |-> rd_addr == $past(rd_addr) + ONE); // R4
  AST_XF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    xfade_start |-> (!wr_en && rd_en && mode_o == 3'd3)); // R5
  AST_XS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfade_start |=> !xfade_start); // R5
  AST_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_zero |-> (wr_en && !rd_en && !slot_right && mode_o == 3'd0)); // R8
  AST_REV_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rev_sel |-> mode_o == 3'd2); // R11

endmodule

// File: tb/sim_rev_ctrl.sv
module sim_rev_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 12, DW = 16, SZW = 8, SHIFT = 4, BTK = 'h20, HOLD = 'h10;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 0, rst_n = 0, smp_stb = 0, xfade_done = 0;
  logic [DW-1:0] smp_left = '0;
  logic [SZW-1:0] buf_size = 8'd4;
  logic wr_en, rd_en, slot_right, mem_zero, rev_sel, xfade_start;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [2:0] mode_o;

  rev_ctrl #(.AW(AW), .DW(DW), .SZW(SZW), .SIZE_SHIFT(SHIFT), .BACKTRACK(BTK), .HOLDOFF(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_left(smp_left), .buf_size(buf_size),
    .xfade_done(xfade_done), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .slot_right(slot_right), .mem_zero(mem_zero), .rev_sel(rev_sel), .xfade_start(xfade_start),
    .mode_o(mode_o));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic lw, lr, lx, lrv, rw, rr, rrt;
  int la, lra, ra, rra, lm;

  localparam logic [16:0] VEC [0:7] = '{
    {16'h3900, 1'b1}, {16'h38FF, 1'b0}, {16'hC6FF, 1'b1}, {16'hC700, 1'b0},
    {16'h7FFF, 1'b1}, {16'h8000, 1'b1}, {16'h0000, 1'b0}, {16'hFFFF, 1'b0}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic period(input logic [15:0] x, input bit dn);
    @(negedge clk); smp_stb = 1; smp_left = x; xfade_done = dn;
    @(negedge clk); smp_stb = 0; xfade_done = 0;
    lw = wr_en; la = int'(wr_addr); lr = rd_en; lra = int'(rd_addr);
    lx = xfade_start; lm = int'(mode_o); lrv = rev_sel;
    @(negedge clk);
    rw = wr_en; ra = int'(wr_addr); rr = rd_en; rra = int'(rd_addr); rrt = slot_right;
  endtask

  task automatic do_reset(input bit poke);
    int n;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(mem_zero && wr_en && wr_addr == 0, "R8 sweep start", int'(wr_addr), 0);
    n = 0;
    while (mem_zero && n < 10000) begin
      if (poke && n < 6) begin smp_stb = 1; smp_left = 16'h7000; end
      else smp_stb = 0;
      @(negedge clk); n++;
    end
    smp_stb = 0;
    chk(n == (1 << AW), "R8 sweep length", n, 1 << AW);
    chk(wr_addr == 1 && !wr_en, "R8 write pointer", int'(wr_addr), 1);
    chk(rd_addr == AW'('h1FF01) && !rd_en, "R8 read start", int'(rd_addr), 'hF01);
    chk(mode_o == 0, "R8 mode", int'(mode_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ew, bot, p, cnt;
    bit hit;
    for (int i = 0; i < 8; i++) begin
      do_reset(1'b0);
      period(VEC[i][16:1], 1'b0);
      chk(lm == (VEC[i][0] ? 1 : 0), "R1 threshold", lm, VEC[i][0] ? 1 : 0);
      chk(lw && rw && la == 2 && ra == 3, "R7 first writes", la, 2);
      chk(!lr && !rr && rrt, "R11 slots", int'(lr), 0);
    end

    do_reset(1'b1);
    chk(mode_o == 0, "R10 strobe during sweep", int'(mode_o), 0);
    @(negedge clk); smp_stb = 1; smp_left = 0;
    @(negedge clk);
    @(negedge clk); smp_stb = 0;
    @(negedge clk);
    chk(wr_addr == 3, "R10 strobe held in slot", int'(wr_addr), 3);
    ew = 3;

    for (int k = 0; k < 3; k++) begin
      period(16'h1000, 1'b0);
      chk(lw && rw && la == ((ew + 1) & MASK) && ra == ((ew + 2) & MASK), "R7 forward writes", la, ew + 1);
      ew = (ew + 2) & MASK;
    end

    period(16'h4000, 1'b0);
    ew = (ew + 2) & MASK;
    bot = (ew - BTK) & MASK;
    chk(lm == 1, "R1 trigger", lm, 1);

    hit = 0;
    for (int k = 0; k < 200 && !hit; k++) begin
      period((k % 3 == 0) ? 16'h7000 : 16'h0100, 1'b0);
      chk(lw && rw && la == ((ew + 1) & MASK), "R3 recording while armed", la, ew + 1);
      ew = (ew + 2) & MASK;
      if (ew == ((bot + (4 << SHIFT)) & MASK)) begin
        hit = 1;
        chk(lm == 2 && lrv, "R3 reverse start", lm, 2);
        chk(lr && rr && lra == ((ew - 3) & MASK) && rra == ((ew - 2) & MASK), "R3 first reads R2", lra, (ew - 3) & MASK);
        p = (ew - 2) & MASK;
      end else begin
        chk(lm == 1, "R9 armed ignores loud", lm, 1);
      end
    end
    chk(hit, "R2 arm match", int'(hit), 1);

    hit = 0; cnt = 0;
    for (int k = 0; k < 200 && !hit; k++) begin
      period(16'h7FFF, 1'b0);
      chk(!lw && !rw, "R7 no write reversing", int'(lw), 0);
      chk(lr && rr && lra == ((p - 3) & MASK) && rra == ((p - 2) & MASK), "R4 reverse reads", lra, (p - 3) & MASK);
      if (p == bot) begin
        hit = 1;
        chk(lx && lm == 3 && !lrv, "R5 crossfade start", lm, 3);
      end else begin
        cnt++;
        if (k < 3) chk(lm == 2 && !lx, "R9 reversing ignores loud", lm, 2);
      end
      p = (p - 2) & MASK;
    end
    chk(cnt == 31, "R5 playback length", cnt, 31);

    for (int k = 0; k < 3; k++) begin
      period(16'h7FFF, 1'b0);
      chk(lw && rw && la == ((ew + 1) & MASK) && ra == ((ew + 2) & MASK), "R5 writes resume", la, ew + 1);
      chk(lr && lra == ((p - 3) & MASK) && lm == 3 && !lx, "R4 crossfade reads", lra, (p - 3) & MASK);
      ew = (ew + 2) & MASK; p = (p - 2) & MASK;
    end
    period(16'h0000, 1'b1);
    chk(lm == 4 && lr && lra == ((p - 3) & MASK), "R6 holdoff entry", lm, 4);
    ew = (ew + 2) & MASK;

    for (int k = 1; k <= HOLD / 2; k++) begin
      period(16'h7FFF, 1'b0);
      chk(lm == ((k < HOLD / 2) ? 4 : 0), "R6 R9 holdoff", lm, (k < HOLD / 2) ? 4 : 0);
      chk(!lr && lw && la == ((ew + 1) & MASK), "R6 holdoff access", la, ew + 1);
      ew = (ew + 2) & MASK;
    end
    period(16'hC000, 1'b0);
    chk(lm == 1, "R1 retrigger", lm, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule